// File: doc/BRIEF.md
# Multi-Lane Video Pixel Distributor

The distributor accepts one video pixel per clock, with an active-low vertical sync, a data-enable and a control word, and spreads the stream over `LANES` byte lanes. Incoming cycles are grouped into sets of `LANES` consecutive cycles that share the same data-enable level. Each complete set leaves the block as one output word. In that word, every lane carries `PIX_W/8` byte slots, and each slot is a data byte plus a K-character flag. The word is marked by a one-cycle `lane_vld` strobe.

During active video the pixels of a set are dealt to the lanes in arrival order, least-significant byte first. During blanking every lane frames the interval with symbols: a start symbol opens the first set, a payload marker opens every later set, and an end symbol closes the last set. The sets strictly between the first and the last carry the control word, so the control word is guarded by `LANES` cycles at each end of the blanking period. The end symbol changes to an end-with-reset variant once after each vertical sync. A run whose length is not a multiple of the lane count is padded with zero cycles, and the block raises a sticky alignment error.

Top module: `vpd_distributor`

## Requirements
- R1: `byte_mode` sets the pixel bytes per lane: 0 gives 3, 1 gives 4, 2 gives 5, and the reserved value 3 behaves as 3. In an active word, slot s of a lane holds pixel bits [8s+7:8s] for s below that count. Higher slots are 0x00, and every K flag is clear.
- R2: Within one word, the cycle at position j of its set (j=0 first) goes to lane j. Lane i, slot s sits at `lane_data[(i*SLOTS+s)*8 +: 8]` and `lane_k[i*SLOTS+s]`.
- R3: In a blanking word, slot 0 of every lane carries K=1. Its value is 0xBC in the first word of the blanking run and 0x3C in every later word.
- R4: Slot SLOTS-1 of every lane carries K=1 with 0x7C in the last word of a blanking run. In any other blanking word it carries 0x00 with K clear.
- R5: The first blanking-end word produced after a falling edge of `vsync_n` uses 0xFC in place of 0x7C. Every other blanking end uses 0x7C.
- R6: Slots 1 to 3 of a blanking word carry the control bytes of that lane's cycle, least-significant first: 1, 2 or 3 bytes for `byte_mode` 0, 1 or 2, and 1 byte for 3. Unused slots are 0x00. In the first and last word of a blanking run these slots are always 0x00, with K clear.
- R7: If a data-enable run ends before its last set is full, the missing cycles are taken as zero pixels and zero control bytes, the set is still emitted as the run's last word, and `align_err` goes high and stays high until reset. Aligned streams never raise it.
- R8: Every completed set is emitted exactly once, in arrival order, with `lane_vld` high for one cycle per word.
- R9: While `rst_n` is low, at a clock edge `lane_vld`, `align_err`, `lane_data` and `lane_k` are cleared and the grouping restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low power-down and reset |
| byte_mode | input | 2 | Bytes-per-pixel select, held static |
| vsync_n | input | 1 | Active-low vertical sync |
| de | input | 1 | Data enable: 1 is active video, 0 is blanking |
| pix | input | PIX_W | Pixel word |
| ctl | input | CTL_W | Control word, used in blanking |
| lane_data | output | LANES*PIX_W | Byte slots of all lanes |
| lane_k | output | LANES*PIX_W/8 | K flag of each byte slot |
| lane_vld | output | 1 | One-cycle strobe for a new output word |
| align_err | output | 1 | Sticky run-length misalignment flag |

## Verification
The assertions assume that `byte_mode` does not change while words are flowing. They also assume `LANES` is 1, 2 or 4 and `PIX_W/8` is at least two more than `CTL_W/8`. The bench therefore changes the mode only while reset is held and keeps the default widths. The end-with-reset check assumes each vertical sync falls inside a blanking run, and no more than once per run. The stimulus lowers `vsync_n` only at the second and third cycle of blanking runs of at least eight cycles, so the falling edge is always seen before that run's end word.

// File: rtl/vpd_pkg.sv
// Package: framing symbol codes and byte-mode decoding shared by the distributor.
package vpd_pkg;

    localparam logic [7:0] SYM_BLANK_START   = 8'hBC;
    localparam logic [7:0] SYM_BLANK_PAYLOAD = 8'h3C;
    localparam logic [7:0] SYM_BLANK_END     = 8'h7C;
    localparam logic [7:0] SYM_BLANK_END_RST = 8'hFC;

    // Pixel bytes carried per lane for a byte-mode code (reserved code acts as 3).
    function automatic int pix_bytes(input logic [1:0] mode);
        case (mode)
            2'd1:    return 4;
            2'd2:    return 5;
            default: return 3;
        endcase
    endfunction

    // Control bytes carried per lane for a byte-mode code (reserved code acts as 1).
    function automatic int ctl_bytes(input logic [1:0] mode);
        case (mode)
            2'd1:    return 2;
            2'd2:    return 3;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/vpd_run_track.sv
// Module: vpd_run_track
// Tracks data-enable runs and the position of each cycle within its set of
// LANES cycles. It reports when the current cycle completes a set, and when a
// run change leaves a partly filled set that must be padded out.
// Assumes: LANES is 1, 2 or 4.
module vpd_run_track #(
    parameter int LANES = 4,
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             de,
    output logic [IDX_W-1:0] slot,
    output logic             grp_done,
    output logic             grp_first,
    output logic             pad_done,
    output logic             pad_first,
    output logic             pad_de
);

    logic [IDX_W-1:0] ph;
    logic             run_de;
    logic             cur_first;
    logic             change;

    // Decode where the current cycle lands and whether a set closes.
    always_comb begin
        change    = (de != run_de);
        pad_done  = change && (ph != '0);
        slot      = change ? '0 : ph;
        grp_done  = (slot == IDX_W'(LANES - 1));
        grp_first = change | cur_first;
        pad_first = cur_first;
        pad_de    = run_de;
    end

    // Advance the set position and remember the run level and first-set status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph        <= '0;
            run_de    <= 1'b0;
            cur_first <= 1'b1;
        end else begin
            ph        <= grp_done ? '0 : slot + 1'b1;
            run_de    <= de;
            cur_first <= grp_done ? 1'b0 : grp_first;
        end
    end

endmodule

// File: rtl/vpd_group_buf.sv
// Module: vpd_group_buf
// Collects the cycles of one set into per-lane slots. A completed or padded
// set moves into a pending register for one cycle, together with its run
// level, its first-set flag and a flag saying it is known to be the run's last.
// Assumes: completion and padding never happen on the same edge.
module vpd_group_buf #(
    parameter int LANES = 4,
    parameter int PIX_W = 40,
    parameter int CTL_W = 24,
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   de,
    input  logic [PIX_W-1:0]       pix,
    input  logic [CTL_W-1:0]       ctl,
    input  logic [IDX_W-1:0]       slot,
    input  logic                   grp_done,
    input  logic                   grp_first,
    input  logic                   pad_done,
    input  logic                   pad_first,
    input  logic                   pad_de,
    output logic                   pend_full,
    output logic                   pend_de,
    output logic                   pend_first,
    output logic                   pend_forced,
    output logic [LANES*PIX_W-1:0] pend_pix,
    output logic [LANES*CTL_W-1:0] pend_ctl
);

    logic [LANES*PIX_W-1:0] buf_pix, merge_pix;
    logic [LANES*CTL_W-1:0] buf_ctl, merge_ctl;

    // Place the current cycle into its lane slot on top of the collected ones.
    for (genvar g = 0; g < LANES; g++) begin : g_merge
        assign merge_pix[g*PIX_W +: PIX_W] = (slot == IDX_W'(g)) ? pix : buf_pix[g*PIX_W +: PIX_W];
        assign merge_ctl[g*CTL_W +: CTL_W] = (slot == IDX_W'(g)) ? ctl : buf_ctl[g*CTL_W +: CTL_W];
    end

    // Fill slots, hand finished sets to the pending stage, clear for the next set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_pix     <= '0;
            buf_ctl     <= '0;
            pend_pix    <= '0;
            pend_ctl    <= '0;
            pend_full   <= 1'b0;
            pend_de     <= 1'b0;
            pend_first  <= 1'b0;
            pend_forced <= 1'b0;
        end else if (pad_done) begin
            pend_pix    <= buf_pix;
            pend_ctl    <= buf_ctl;
            pend_full   <= 1'b1;
            pend_de     <= pad_de;
            pend_first  <= pad_first;
            pend_forced <= 1'b1;
            buf_pix     <= (LANES*PIX_W)'(pix);
            buf_ctl     <= (LANES*CTL_W)'(ctl);
        end else if (grp_done) begin
            pend_pix    <= merge_pix;
            pend_ctl    <= merge_ctl;
            pend_full   <= 1'b1;
            pend_de     <= de;
            pend_first  <= grp_first;
            pend_forced <= 1'b0;
            buf_pix     <= '0;
            buf_ctl     <= '0;
        end else begin
            buf_pix     <= merge_pix;
            buf_ctl     <= merge_ctl;
            pend_full   <= 1'b0;
        end
    end

    // A set cannot close normally on the edge that pads the previous one.
    assert_pad_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(grp_done && pad_done));

endmodule

// File: rtl/vpd_lane_fmt.sv
// Module: vpd_lane_fmt
// Formats one lane's byte slots from its pixel or control word. Active sets
// carry pixel bytes. Blanking sets carry a start or payload marker in the
// first slot, control bytes in the middle slots and an end symbol in the
// last slot.
// Assumes: PIX_W/8 >= CTL_W/8 + 2.
module vpd_lane_fmt
    import vpd_pkg::*;
#(
    parameter int PIX_W = 40,
    parameter int CTL_W = 24,
    localparam int SLOTS = PIX_W / 8,
    localparam int CTL_SLOTS = CTL_W / 8
) (
    input  logic [1:0]       mode,
    input  logic             is_act,
    input  logic             first,
    input  logic             last,
    input  logic             ber,
    input  logic [PIX_W-1:0] pix,
    input  logic [CTL_W-1:0] ctl,
    output logic [PIX_W-1:0] data,
    output logic [SLOTS-1:0] k
);

    // Build the slot bytes and K flags of this lane.
    always_comb begin
        data = '0;
        k    = '0;
        if (is_act) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (s < pix_bytes(mode)) data[s*8 +: 8] = pix[s*8 +: 8];
            end
        end else begin
            data[7:0] = first ? SYM_BLANK_START : SYM_BLANK_PAYLOAD;
            k[0]      = 1'b1;
            if (!first && !last) begin
                for (int c = 0; c < CTL_SLOTS; c++) begin
                    if (c < ctl_bytes(mode)) data[(c+1)*8 +: 8] = ctl[c*8 +: 8];
                end
            end
            if (last) begin
                data[PIX_W-8 +: 8] = ber ? SYM_BLANK_END_RST : SYM_BLANK_END;
                k[SLOTS-1]         = 1'b1;
            end
        end
    end

endmodule

// File: rtl/vpd_distributor.sv
// Module: vpd_distributor (top)
// Distributes a one-pixel-per-clock video stream over LANES byte lanes. Sets
// of LANES cycles with equal data-enable become one output word. Blanking runs
// are framed per lane. The end of a blanking run is decided from the
// data-enable level of the cycle after the set closes.
// Assumes: byte_mode is static while running; LANES is 1, 2 or 4.
module vpd_distributor
    import vpd_pkg::*;
#(
    parameter int LANES = 4,
    parameter int PIX_W = 40,
    parameter int CTL_W = 24,
    localparam int SLOTS = PIX_W / 8,
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             byte_mode,
    input  logic                   vsync_n,
    input  logic                   de,
    input  logic [PIX_W-1:0]       pix,
    input  logic [CTL_W-1:0]       ctl,
    output logic [LANES*PIX_W-1:0] lane_data,
    output logic [LANES*SLOTS-1:0] lane_k,
    output logic                   lane_vld,
    output logic                   align_err
);

    logic [IDX_W-1:0]       slot;
    logic                   grp_done, grp_first, pad_done, pad_first, pad_de;
    logic                   pend_full, pend_de, pend_first, pend_forced;
    logic [LANES*PIX_W-1:0] pend_pix, fmt_data;
    logic [LANES*CTL_W-1:0] pend_ctl;
    logic [LANES*SLOTS-1:0] fmt_k;
    logic                   is_last, emit_end, vs_prev, vs_flag, vs_fall;

    vpd_run_track #(.LANES(LANES)) i_track (
        .clk(clk), .rst_n(rst_n), .de(de), .slot(slot),
        .grp_done(grp_done), .grp_first(grp_first),
        .pad_done(pad_done), .pad_first(pad_first), .pad_de(pad_de)
    );

    vpd_group_buf #(.LANES(LANES), .PIX_W(PIX_W), .CTL_W(CTL_W)) i_buf (
        .clk(clk), .rst_n(rst_n), .de(de), .pix(pix), .ctl(ctl), .slot(slot),
        .grp_done(grp_done), .grp_first(grp_first), .pad_done(pad_done),
        .pad_first(pad_first), .pad_de(pad_de),
        .pend_full(pend_full), .pend_de(pend_de), .pend_first(pend_first),
        .pend_forced(pend_forced), .pend_pix(pend_pix), .pend_ctl(pend_ctl)
    );

    // A pending set is its run's last when it was padded or the level has changed.
    always_comb begin
        is_last  = pend_forced | (de != pend_de);
        emit_end = pend_full & ~pend_de & is_last;
        vs_fall  = vs_prev & ~vsync_n;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        vpd_lane_fmt #(.PIX_W(PIX_W), .CTL_W(CTL_W)) i_fmt (
            .mode(byte_mode), .is_act(pend_de), .first(pend_first),
            .last(is_last), .ber(vs_flag),
            .pix(pend_pix[l*PIX_W +: PIX_W]), .ctl(pend_ctl[l*CTL_W +: CTL_W]),
            .data(fmt_data[l*PIX_W +: PIX_W]), .k(fmt_k[l*SLOTS +: SLOTS])
        );
    end

    // Remember a vsync fall until a blanking end has consumed it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_prev <= 1'b1;
            vs_flag <= 1'b0;
        end else begin
            vs_prev <= vsync_n;
            vs_flag <= vs_fall | (vs_flag & ~emit_end);
        end
    end

    // Register the output word and the sticky alignment error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_data <= '0;
            lane_k    <= '0;
            lane_vld  <= 1'b0;
            align_err <= 1'b0;
        end else begin
            lane_vld <= pend_full;
            if (pend_full) begin
                lane_data <= fmt_data;
                lane_k    <= fmt_k;
            end
            if (pad_done) align_err <= 1'b1;
        end
    end

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |=> align_err);

    assert_pend_emitted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pend_full |=> lane_vld);

    assert_end_in_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_vld && lane_k[SLOTS-1]) |-> lane_k[0]);

    assert_active_no_k_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_vld && !lane_k[0]) |-> (lane_k[SLOTS-1:0] == '0));

    assert_ber_consumed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vs_flag) |-> (lane_vld && lane_k[SLOTS-1]
                            && lane_data[PIX_W-8 +: 8] == SYM_BLANK_END_RST));

endmodule

// File: tb/test_vpd_distributor.sv
module test_vpd_distributor;

    localparam int L  = 4;
    localparam int PW = 40;
    localparam int CW = 24;
    localparam int SL = PW / 8;
    localparam int MAXN = 2048;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       byte_mode = 2'd0;
    logic             vsync_n = 1'b1;
    logic             de = 1'b0;
    logic [PW-1:0]    pix = '0;
    logic [CW-1:0]    ctl = '0;
    logic [L*PW-1:0]  lane_data;
    logic [L*SL-1:0]  lane_k;
    logic             lane_vld;
    logic             align_err;

    vpd_distributor #(.LANES(L), .PIX_W(PW), .CTL_W(CW)) i_vpd_distributor (
        .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .vsync_n(vsync_n),
        .de(de), .pix(pix), .ctl(ctl), .lane_data(lane_data), .lane_k(lane_k),
        .lane_vld(lane_vld), .align_err(align_err)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic          s_de [MAXN];
    logic          s_vsn[MAXN];
    logic [PW-1:0] s_pix[MAXN];
    logic [CW-1:0] s_ctl[MAXN];
    int n;
    int r_start[64];
    int r_len[64];
    bit r_de[64];
    bit r_vs[64];
    int nrun;

    logic [L*PW-1:0] exp_d[$];
    logic [L*SL-1:0] exp_k[$];
    string           exp_tag[$];
    logic [L*PW-1:0] got_d[$];
    logic [L*SL-1:0] got_k[$];

    task automatic check(string req, logic [L*PW+L*SL-1:0] act, logic [L*PW+L*SL-1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Expected byte slots of one lane, written from the requirements.
    function automatic logic [SL+PW-1:0] lane_word(bit act, bit first, bit last, bit ber,
                                                   logic [1:0] m, logic [PW-1:0] p, logic [CW-1:0] c);
        logic [PW-1:0] d = '0;
        logic [SL-1:0] k = '0;
        int pb = (m == 2'd1) ? 4 : (m == 2'd2) ? 5 : 3;
        int cb = (m == 2'd1) ? 2 : (m == 2'd2) ? 3 : 1;
        if (act) begin
            for (int s = 0; s < pb; s++) d[s*8 +: 8] = p[s*8 +: 8];
        end else begin
            d[7:0] = first ? 8'hBC : 8'h3C;
            k[0] = 1'b1;
            if (!first && !last)
                for (int q = 0; q < cb; q++) d[(q+1)*8 +: 8] = c[q*8 +: 8];
            if (last) begin
                d[PW-8 +: 8] = ber ? 8'hFC : 8'h7C;
                k[SL-1] = 1'b1;
            end
        end
        return {k, d};
    endfunction

    task automatic add_run(bit d, int len, bit vs);
        r_start[nrun] = n;
        r_len[nrun] = len;
        r_de[nrun] = d;
        r_vs[nrun] = vs;
        nrun++;
        for (int i = 0; i < len; i++) begin
            s_de[n]  = d;
            s_vsn[n] = !(vs && (i == 1 || i == 2));
            s_pix[n] = {$urandom, $urandom};
            s_ctl[n] = CW'($urandom);
            n++;
        end
    endtask

    task automatic build_stim(bit misaligned);
        int a, b;
        n = 0;
        nrun = 0;
        for (int ln = 0; ln < 12; ln++) begin
            if (misaligned) begin
                b = (ln == 0) ? 10 : $urandom_range(3, 14);
                a = (ln == 0) ? 6 : $urandom_range(1, 14);
            end else begin
                b = (ln == 0) ? 4 : (ln == 1) ? 8 : (ln == 2) ? 12 : 4 * $urandom_range(1, 6);
                a = 4 * $urandom_range(1, 6);
            end
            add_run(1'b0, b, (b >= 8) && ((ln == 2) || ($urandom_range(0, 2) == 0)));
            add_run(1'b1, a, 1'b0);
        end
        add_run(1'b0, 12, 1'b1);
    endtask

    task automatic build_exp(logic [1:0] m);
        exp_d.delete();
        exp_k.delete();
        exp_tag.delete();
        for (int r = 0; r < nrun; r++) begin
            int g = (r_len[r] + L - 1) / L;
            for (int j = 0; j < g; j++) begin
                logic [L*PW-1:0] ed = '0;
                logic [L*SL-1:0] ek = '0;
                bit first = (j == 0);
                bit last = (j == g - 1);
                string tag;
                for (int i = 0; i < L; i++) begin
                    int pos = j * L + i;
                    logic [PW-1:0] p = (pos < r_len[r]) ? s_pix[r_start[r] + pos] : '0;
                    logic [CW-1:0] c = (pos < r_len[r]) ? s_ctl[r_start[r] + pos] : '0;
                    logic [SL+PW-1:0] w = lane_word(r_de[r], first, last, r_vs[r], m, p, c);
                    ed[i*PW +: PW] = w[PW-1:0];
                    ek[i*SL +: SL] = w[SL+PW-1:PW];
                end
                if (last && (r_len[r] % L != 0)) tag = "R7 padded set";
                else if (r_de[r]) tag = "R1 R2 active set";
                else if (last && r_vs[r]) tag = "R5 end-with-reset";
                else if (first || last) tag = "R3 R4 blanking edge";
                else tag = "R6 control payload";
                exp_d.push_back(ed);
                exp_k.push_back(ek);
                exp_tag.push_back(tag);
            end
        end
    endtask

    task automatic sample();
        if (lane_vld) begin
            got_d.push_back(lane_data);
            got_k.push_back(lane_k);
        end
    endtask

    task automatic run_phase(logic [1:0] m, bit misaligned);
        build_stim(misaligned);
        build_exp(m);
        got_d.delete();
        got_k.delete();
        rst_n = 1'b0;
        byte_mode = m;
        de = 1'b0;
        vsync_n = 1'b1;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset clears outputs", {lane_data, lane_k}, '0);
        check("R9 reset clears strobe and error", {{(L*PW+L*SL-2){1'b0}}, lane_vld, align_err}, '0);
        for (int c = 0; c < n + 16; c++) begin
            if (c > 0) begin
                @(negedge clk);
                sample();
            end
            rst_n = 1'b1;
            if (c < n) begin
                de = s_de[c];
                vsync_n = s_vsn[c];
                pix = s_pix[c];
                ctl = s_ctl[c];
            end else begin
                de = 1'b1;
                vsync_n = 1'b1;
                pix = {$urandom, $urandom};
                ctl = '0;
            end
        end
        repeat (6) begin
            @(negedge clk);
            sample();
        end
        // R8: every expected word present, in order
        check("R8 word count", (L*PW+L*SL)'(got_d.size() >= exp_d.size()), (L*PW+L*SL)'(1));
        for (int e = 0; e < exp_d.size(); e++) begin
            if (e < got_d.size())
                check(exp_tag[e], {got_d[e], got_k[e]}, {exp_d[e], exp_k[e]});
        end
        // R7: sticky error only for misaligned streams
        check("R7 alignment error flag", (L*PW+L*SL)'(align_err), (L*PW+L*SL)'(misaligned));
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        run_phase(2'd0, 1'b0);
        run_phase(2'd1, 1'b0);
        run_phase(2'd2, 1'b0);
        run_phase(2'd3, 1'b0);
        run_phase(2'd2, 1'b1);
        run_phase(2'd1, 1'b1);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R8 watchdog actual=%0d cycles expected=completion", 200000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule